// File: doc/BRIEF.md
# Write-only I2C control register slave with blanking-aligned commit

This block is a small I2C target that loads two 8-bit control registers for a video encoder. The registers are write-only: a bus master sends a start, the device address with the direction bit at 0, a one-byte register index and then one or more data bytes. The block acknowledges each byte it accepts by pulling SDA low through an open-drain enable. The block samples SCL and SDA on its own system clock after a two-flop synchroniser. It never stretches the clock.

Register index 0 is the mode register and index 1 is the control register. Most bits take effect as soon as their data byte has been received. Two fields are different: the black-level bit (mode bit 5) and the overlay-level field (control bits 1:0). Each of these is written into a shadow copy and reaches the output only on a clock cycle in which the vertical-blanking strobe is high. This keeps a visible level from changing in the middle of a picture. When a frame carries several data bytes, every one of them goes to the same register index, because the index never advances.

Top module: `i2c_vblank_regs`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits are 7'h46 when `addr_sel_i` is 1, or 7'h44 when it is 0, and whose bit 0 is 0. It withholds the acknowledge for any other address value.
- R2: An address byte with bit 0 equal to 1 (a read request) is not acknowledged, and the rest of that frame changes no register.
- R3: Index 0 selects the mode register and index 1 selects the control register. Any other index is not acknowledged, and the block then ignores the bus, including later data bytes, until the next start condition.
- R4: Every data byte in a frame is acknowledged and written to the index given by that frame's index byte. The index does not increment, so the other register keeps its value.
- R5: Immediate bits take their new value in the cycle after the write strobe, without any blanking strobe. The immediate bits are mode bits 7:6 and 4:0, and control bit 2.
- R6: The deferred fields are mode bit 5 and control bits 1:0. They change only after a cycle in which `vblank_i` is high, and they then take the most recently written value.
- R7: After reset the mode register reads 8'h10 and the control register reads 8'h00. Control bits 7:3 are not defined and always read 0.
- R8: For an accepted byte, `sda_pull_o` is asserted while SCL is low after the eighth bit. It stays asserted through the ninth SCL clock and is released after the following SCL fall. It is never asserted outside such a slot.
- R9: A start condition in the middle of a frame begins address matching again, whatever state the frame had reached.
- R10: When a data byte's write strobe and a high `vblank_i` fall in the same cycle, the deferred fields take the shadow value from before that write. The new value waits for the next blanking cycle.
- R11: A stop condition returns the block to idle with `sda_pull_o` released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line, asynchronous |
| sda_i | input | 1 | I2C data line as seen on the bus, asynchronous |
| addr_sel_i | input | 1 | Chooses between the two device addresses |
| vblank_i | input | 1 | Vertical-blanking strobe, synchronous to clk |
| sda_pull_o | output | 1 | High to pull SDA low (acknowledge) |
| mode_reg_o | output | 8 | Current mode register contents |
| ctrl_reg_o | output | 8 | Current control register contents |

## Verification
The write strobe that ends a data byte and a blanking cycle can fall in the same clock cycle. In that cycle the deferred fields are loaded from the shadow at the same moment the shadow itself is being rewritten. The bench provokes this by counting the synchroniser and edge-detect registers from the SCL fall after the eighth data bit. It then raises `vblank_i` for exactly the cycle in which the register bank sees the strobe. It judges the result by requiring the old overlay level to persist after the frame, and the new one to appear only after a later blanking pulse. A behavioural model compared on every idle clock also covers ordinary blanking pulses that arrive between frames.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_REGS = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_SUB, ST_DATA} rx_state_t;

  // value loaded by reset
  function automatic logic [7:0] reg_reset(input int idx);
    return (idx == 0) ? 8'h10 : 8'h00;
  endfunction

  // bits that exist; the rest stay 0
  function automatic logic [7:0] reg_defined(input int idx);
    return (idx == 0) ? 8'hFF : 8'h07;
  endfunction

  // bits that wait for vertical blanking
  function automatic logic [7:0] reg_defer(input int idx);
    return (idx == 0) ? 8'h20 : 8'h03;
  endfunction
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int W       = 2,
  parameter int STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2cw_rx.sv
module i2cw_rx
  import i2cw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR_HI = 7'h46,
  parameter logic [6:0] DEV_ADDR_LO = 7'h44,
  parameter int NREGS = NUM_REGS,
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             addr_sel,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             sda_pull,
  output logic             stop_det
);
  localparam logic [7:0] NREG8 = 8'(NREGS);

  rx_state_t  state;
  logic       scl_q, sda_q;
  logic [2:0] cnt;
  logic [7:0] shreg;
  logic       byte_full, ack_slot, byte_ok;
  logic       scl_rise, scl_fall, start_det;
  logic [6:0] dev_addr;

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign dev_addr  = addr_sel ? DEV_ADDR_HI : DEV_ADDR_LO;

  always_comb begin
    case (state)
      ST_ADDR: byte_ok = (shreg == {dev_addr, 1'b0});
      ST_SUB:  byte_ok = (shreg < NREG8);
      ST_DATA: byte_ok = 1'b1;
      default: byte_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      state     <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      byte_full <= 1'b0;
      ack_slot  <= 1'b0;
      sda_pull  <= 1'b0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
      wr_en <= 1'b0;
      if (start_det) begin
        state     <= ST_ADDR;
        cnt       <= '0;
        byte_full <= 1'b0;
        ack_slot  <= 1'b0;
        sda_pull  <= 1'b0;
      end else if (stop_det) begin
        state     <= ST_IDLE;
        byte_full <= 1'b0;
        ack_slot  <= 1'b0;
        sda_pull  <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (scl_rise && !ack_slot && !byte_full) begin
          shreg <= {shreg[6:0], sda_s};
          cnt   <= cnt + 3'd1;
          if (cnt == 3'd7) byte_full <= 1'b1;
        end else if (scl_fall) begin
          if (byte_full) begin
            byte_full <= 1'b0;
            if (byte_ok) begin
              ack_slot <= 1'b1;
              sda_pull <= 1'b1;
              case (state)
                ST_ADDR: state <= ST_SUB;
                ST_SUB: begin
                  wr_idx <= shreg[IDX_W-1:0];
                  state  <= ST_DATA;
                end
                default: begin
                  wr_en   <= 1'b1;
                  wr_data <= shreg;
                end
              endcase
            end else begin
              state <= ST_IDLE;
            end
          end else if (ack_slot) begin
            ack_slot <= 1'b0;
            sda_pull <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2cw_regbank.sv
module i2cw_regbank
  import i2cw_pkg::*;
#(
  parameter int NREGS = NUM_REGS,
  parameter int W     = REG_W,
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data,
  input  logic             vblank,
  output logic [NREGS*W-1:0] regs_o
);
  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    localparam logic [W-1:0] DEF = W'(reg_defined(g));
    localparam logic [W-1:0] DFR = W'(reg_defer(g));
    localparam logic [W-1:0] RST = W'(reg_reset(g));

    logic [W-1:0] cur, shadow, upd, nxt;
    logic         hit;

    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_comb begin
      upd = (hit ? (DEF & ~DFR) : '0) | (vblank ? DFR : '0);
      nxt = (wr_data & ~DFR) | (shadow & DFR);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        cur    <= RST;
        shadow <= RST & DFR;
      end else begin
        cur <= (cur & ~upd) | (nxt & upd);
        if (hit) shadow <= wr_data & DFR;
      end
    end

    assign regs_o[g*W +: W] = cur;
  end
endmodule

// File: rtl/i2c_vblank_regs.sv
module i2c_vblank_regs #(
  parameter logic [6:0] DEV_ADDR_HI = 7'h46,
  parameter logic [6:0] DEV_ADDR_LO = 7'h44,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       addr_sel_i,
  input  logic       vblank_i,
  output logic       sda_pull_o,
  output logic [7:0] mode_reg_o,
  output logic [7:0] ctrl_reg_o
);
  localparam int NREGS = i2cw_pkg::NUM_REGS;
  localparam int W     = i2cw_pkg::REG_W;
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic             scl_s, sda_s, wr_en, stop_det;
  logic [IDX_W-1:0] wr_idx;
  logic [W-1:0]     wr_data;
  logic [NREGS*W-1:0] regs;

  i2cw_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q({scl_s, sda_s})
  );

  i2cw_rx #(.DEV_ADDR_HI(DEV_ADDR_HI), .DEV_ADDR_LO(DEV_ADDR_LO), .NREGS(NREGS)) u_rx (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s), .addr_sel(addr_sel_i),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sda_pull(sda_pull_o), .stop_det(stop_det)
  );

  i2cw_regbank #(.NREGS(NREGS), .W(W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .vblank(vblank_i), .regs_o(regs)
  );

  assign mode_reg_o = regs[W-1:0];
  assign ctrl_reg_o = regs[2*W-1:W];
endmodule

// File: rtl/i2cw_chk.sv
module i2cw_chk (
  input logic       clk,
  input logic       rst,
  input logic       vblank_i,
  input logic       sda_pull_o,
  input logic [7:0] mode_reg_o,
  input logic [7:0] ctrl_reg_o,
  input logic       wr_en,
  input logic       scl_s,
  input logic       stop_det
);
  AST_RESET_VALUES: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mode_reg_o == 8'h10 && ctrl_reg_o == 8'h00)); // R7

  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (rst)
    ctrl_reg_o[7:3] == 5'd0); // R7

  AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(vblank_i) |-> ($stable(mode_reg_o[5]) && $stable(ctrl_reg_o[1:0]))); // R6

  AST_IMM_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> ($stable(mode_reg_o & 8'hDF) && $stable(ctrl_reg_o[2]))); // R5

  AST_ACK_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_o) |-> !scl_s); // R8

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_pull_o); // R11
endmodule

bind i2c_vblank_regs i2cw_chk u_chk (
  .clk(clk), .rst(rst), .vblank_i(vblank_i), .sda_pull_o(sda_pull_o),
  .mode_reg_o(mode_reg_o), .ctrl_reg_o(ctrl_reg_o), .wr_en(wr_en),
  .scl_s(scl_s), .stop_det(stop_det)
);

// File: tb/test_i2c_vblank_regs.sv
`timescale 1ns/1ps
module test_i2c_vblank_regs;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b0, vblank = 1'b0;
  logic sda_bus, sda_pull;
  logic [7:0] mode_o, ctrl_o;
  int nvec = 0, nfail = 0;
  bit busy = 1'b1;
  bit done = 1'b0;

  // model state
  logic [7:0] m_imm_mode = 8'h10, m_imm_ctrl = 8'h00;
  logic       sh5 = 1'b0, m_def5;
  logic [1:0] shc = 2'b00, m_defc;
  logic [7:0] exp_mode, exp_ctrl;

  always #2 clk = ~clk;
  assign sda_bus = sda_m & ~sda_pull;

  i2c_vblank_regs i_i2c_vblank_regs (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .addr_sel_i(addr_sel),
    .vblank_i(vblank), .sda_pull_o(sda_pull), .mode_reg_o(mode_o), .ctrl_reg_o(ctrl_o)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_def5 <= 1'b0;
      m_defc <= 2'b00;
    end else if (vblank) begin
      m_def5 <= sh5;
      m_defc <= shc;
    end
  end

  assign exp_mode = (m_imm_mode & 8'hDF) | {2'b00, m_def5, 5'b0};
  assign exp_ctrl = (m_imm_ctrl & 8'h04) | {6'b0, m_defc};

  // per-clock comparison while the bus is idle (R5 R6 R7 R11)
  always @(negedge clk) begin
    if (!rst && !busy && !done) begin
      nvec++;
      if (mode_o !== exp_mode || ctrl_o !== exp_ctrl || sda_pull !== 1'b0) begin
        nfail++;
        $display("FAIL R6/R11 idle compare: mode=%h exp=%h ctrl=%h exp=%h pull=%b exp=0",
                 mode_o, exp_mode, ctrl_o, exp_ctrl, sda_pull);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    busy = 1'b1;
    sda_m = 1'b0;
    wait_clk(HALF);
    scl_m = 1'b0;
  endtask

  task automatic bus_restart();
    wait_clk(2);
    sda_m = 1'b1;
    wait_clk(HALF - 2);
    scl_m = 1'b1;
    wait_clk(HALF);
    sda_m = 1'b0;
    wait_clk(HALF);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wait_clk(2);
    sda_m = 1'b0;
    wait_clk(HALF - 2);
    scl_m = 1'b1;
    wait_clk(HALF);
    sda_m = 1'b1;
    wait_clk(HALF);
    check(sda_pull == 1'b0, "R11 pull after stop", {7'b0, sda_pull}, 8'h00);
    busy = 1'b0;
  endtask

  // one byte plus the acknowledge clock; collide raises vblank in the write-strobe cycle
  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag, input bit collide);
    for (int i = 7; i >= 0; i--) begin
      wait_clk(2);
      sda_m = b[i];
      wait_clk(HALF - 2);
      scl_m = 1'b1;
      wait_clk(HALF);
      scl_m = 1'b0;
    end
    wait_clk(1);
    sda_m = 1'b1;
    wait_clk(2);
    if (collide) vblank = 1'b1;
    wait_clk(1);
    vblank = 1'b0;
    wait_clk(HALF - 4);
    scl_m = 1'b1;
    wait_clk(HALF / 2);
    check(sda_pull == exp_ack, tag, {7'b0, sda_pull}, {7'b0, exp_ack});
    wait_clk(HALF / 2);
    scl_m = 1'b0;
    wait_clk(4);
    check(sda_pull == 1'b0, "R8 release after ninth clock", {7'b0, sda_pull}, 8'h00);
  endtask

  task automatic blank_pulse();
    vblank = 1'b1;
    wait_clk(1);
    vblank = 1'b0;
    wait_clk(2);
  endtask

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(1);
    busy = 1'b0;
    check(mode_o == 8'h10, "R7 mode reset", mode_o, 8'h10);
    check(ctrl_o == 8'h00, "R7 ctrl reset", ctrl_o, 8'h00);

    // R1 R5: address 7'h44, mode write
    bus_start();
    send_byte(8'h88, 1'b1, "R1 addr ack sel0", 1'b0);
    send_byte(8'h00, 1'b1, "R3 index 0 ack", 1'b0);
    send_byte(8'hE7, 1'b1, "R4 data ack", 1'b0);
    m_imm_mode = 8'hE7; sh5 = 1'b1;
    bus_stop();
    check(mode_o == 8'hC7, "R5 immediate bits, R6 bit5 held", mode_o, 8'hC7);
    blank_pulse();
    check(mode_o == 8'hE7, "R6 bit5 after blanking", mode_o, 8'hE7);

    // R1 with select 1, control register, R7 undefined bits
    addr_sel = 1'b1;
    bus_start();
    send_byte(8'h8C, 1'b1, "R1 addr ack sel1", 1'b0);
    send_byte(8'h01, 1'b1, "R3 index 1 ack", 1'b0);
    send_byte(8'hFF, 1'b1, "R4 data ack", 1'b0);
    m_imm_ctrl = 8'hFF; shc = 2'b11;
    bus_stop();
    check(ctrl_o == 8'h04, "R7 undefined zero, R5 bit2", ctrl_o, 8'h04);
    blank_pulse();
    check(ctrl_o == 8'h07, "R6 overlay level after blanking", ctrl_o, 8'h07);

    // R1 negative: wrong address for select 0
    addr_sel = 1'b0;
    bus_start();
    send_byte(8'h8C, 1'b0, "R1 addr nack", 1'b0);
    send_byte(8'h00, 1'b0, "R1 ignored after nack", 1'b0);
    send_byte(8'h00, 1'b0, "R1 ignored after nack", 1'b0);
    bus_stop();
    check(mode_o == 8'hE7, "R1 mode untouched", mode_o, 8'hE7);

    // R2: read request
    bus_start();
    send_byte(8'h89, 1'b0, "R2 read nack", 1'b0);
    send_byte(8'h01, 1'b0, "R2 ignored", 1'b0);
    send_byte(8'h00, 1'b0, "R2 ignored", 1'b0);
    bus_stop();
    check(ctrl_o == 8'h07, "R2 ctrl untouched", ctrl_o, 8'h07);

    // R3: missing index
    bus_start();
    send_byte(8'h88, 1'b1, "R3 addr ack", 1'b0);
    send_byte(8'h05, 1'b0, "R3 bad index nack", 1'b0);
    send_byte(8'h00, 1'b0, "R3 data ignored", 1'b0);
    bus_stop();
    check(mode_o == 8'hE7, "R3 mode untouched", mode_o, 8'hE7);
    check(ctrl_o == 8'h07, "R3 ctrl untouched", ctrl_o, 8'h07);

    // R4: three bytes to index 1, no increment
    bus_start();
    send_byte(8'h88, 1'b1, "R4 addr ack", 1'b0);
    send_byte(8'h01, 1'b1, "R4 index ack", 1'b0);
    send_byte(8'h00, 1'b1, "R4 byte1 ack", 1'b0);
    send_byte(8'h04, 1'b1, "R4 byte2 ack", 1'b0);
    send_byte(8'h02, 1'b1, "R4 byte3 ack", 1'b0);
    m_imm_ctrl = 8'h02; shc = 2'b10;
    bus_stop();
    check(ctrl_o == 8'h03, "R4 last byte wins", ctrl_o, 8'h03);
    check(mode_o == 8'hE7, "R4 no increment into mode", mode_o, 8'hE7);
    blank_pulse();
    check(ctrl_o == 8'h02, "R4 deferred last byte", ctrl_o, 8'h02);

    // R9: repeated start restarts matching
    bus_start();
    send_byte(8'h88, 1'b1, "R9 addr ack", 1'b0);
    send_byte(8'h00, 1'b1, "R9 index ack", 1'b0);
    bus_restart();
    send_byte(8'h8C, 1'b0, "R9 restart wrong addr nack", 1'b0);
    send_byte(8'h00, 1'b0, "R9 data ignored", 1'b0);
    bus_restart();
    send_byte(8'h88, 1'b1, "R9 restart addr ack", 1'b0);
    send_byte(8'h00, 1'b1, "R9 index ack", 1'b0);
    send_byte(8'h10, 1'b1, "R9 data ack", 1'b0);
    m_imm_mode = 8'h10; sh5 = 1'b0;
    bus_stop();
    check(mode_o == 8'h30, "R9 write after restart", mode_o, 8'h30);
    blank_pulse();
    check(mode_o == 8'h10, "R9 bit5 cleared by blanking", mode_o, 8'h10);

    // R10: blanking in the write-strobe cycle
    bus_start();
    send_byte(8'h88, 1'b1, "R10 addr ack", 1'b0);
    send_byte(8'h01, 1'b1, "R10 index ack", 1'b0);
    send_byte(8'h01, 1'b1, "R10 data ack", 1'b1);
    m_imm_ctrl = 8'h01; shc = 2'b01;
    bus_stop();
    check(ctrl_o == 8'h02, "R10 old level kept on collision", ctrl_o, 8'h02);
    blank_pulse();
    check(ctrl_o == 8'h01, "R10 new level on next blanking", ctrl_o, 8'h01);

    wait_clk(10);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule